// File: doc/BRIEF.md
# Converter Fault and Start-up Sequencer

This block is the digital control state machine of a switching regulator. It decides when the power stage may switch and when it must be held in high impedance. It produces a digital soft-start reference code that ramps up when the converter is enabled and ramps down when it is disabled. It also arbitrates three protection inputs: input under-voltage, junction over-temperature and over-current. The analog parts (modulator, error amplifier, soft-start capacitor) sit outside it. They consume the ramp code and the switching enable.

An over-current event turns switching off for a fixed hiccup time and then starts again with a full soft-start. This repeats for as long as the overload remains. A thermal trip holds the converter off until the temperature has dropped by a programmable hysteresis. Disabling performs a controlled ramp-down. The internal circuits stay active until the code reaches zero.

Top module: `conv_seq`

## Requirements
- R1: After reset the block is idle: `sw_en`=0, `stage_hiz`=1, `ramp_code`=0, `ramp_dir`=0, `core_active`=0, `in_reg`=0.
- R2: With `en_req` high and no fault, switching starts on the next clock. `ramp_dir`=1 while rising. `ramp_code` rises by RAMP_STEP once every PRESCALE cycles, and the first increment lands PRESCALE cycles after switching starts.
- R3: `ramp_code` saturates at RAMP_FINAL, so the last step may be shorter. It never exceeds that value and never wraps. It then holds while enabled.
- R4: `in_reg` is 1 exactly when `ramp_code` >= REG_CODE.
- R5: While `uv_flag` is 1, from any state, the next cycle shows `sw_en`=0, `stage_hiz`=1, `ramp_code`=0 and `core_active`=0. After the flag clears with enable high, a soft-start begins from zero.
- R6: A thermal trip occurs when `temp_code` > `temp_trip` (equal does not trip). It turns switching off and clears the ramp. Restart happens only once `temp_code` <= `temp_trip`-`temp_hyst`, with that threshold saturating at 0.
- R7: `oc_flag` while switching sets `stage_hiz`=1 and clears the ramp on the next cycle. Switching stays off for exactly HICCUP_CYC cycles with `core_active`=1, and then a soft-start follows. This repeats while the overload persists. `oc_flag` has no effect while the block is not switching.
- R8: Fault priority is under-voltage, then thermal, then over-current. When several faults are raised at once the higher one wins, and a lower fault cannot displace a higher fault state.
- R9: When `en_req` falls, the ramp falls by RAMP_STEP every PRESCALE cycles with `ramp_dir`=0, `sw_en`=1 and `core_active`=1. One cycle after the code reaches 0, the block is idle with `core_active`=0.
- R10: Raising `en_req` during ramp-down resumes the rise from the current code. The code is not reset, and `ramp_dir` returns to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Converter enable request |
| uv_flag | input | 1 | Input under-voltage comparator output (hysteretic) |
| oc_flag | input | 1 | Over-current comparator output |
| temp_code | input | TEMP_W | Digitized junction temperature |
| temp_trip | input | TEMP_W | Thermal trip level |
| temp_hyst | input | TEMP_W | Thermal restart hysteresis |
| sw_en | output | 1 | Power stage switching enable |
| stage_hiz | output | 1 | Both power switches in high impedance |
| ramp_code | output | RAMP_W | Soft-start reference code |
| ramp_dir | output | 1 | 1 = ramping up or holding, 0 = ramping down or off |
| core_active | output | 1 | Internal circuits powered |
| in_reg | output | 1 | Reference is at or beyond the regulation point |

## Verification
The bench targets three corner cases. The first is the last soft-start step that must clip at the final code: a design that wraps or overshoots would show a code above the final value or a jump back near zero. The second is the exact length of the hiccup window. An off-by-one counter would release switching one cycle early or late against the reference model. The third is the temperature boundary. The bench holds the temperature exactly at the trip level, which must not trip, and one degree above the restart threshold, where switching must stay off, so that a wrong comparison restarts too early. It also raises all three faults together: a design that serves over-current first would show `core_active` high from the hiccup state instead of low from lockout. Re-enabling mid ramp-down exposes a design that resets the code to zero.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RISE   = 3'd1,
    ST_HOLD   = 3'd2,
    ST_FALL   = 3'd3,
    ST_LOCK   = 3'd4,
    ST_HOT    = 3'd5,
    ST_HICCUP = 3'd6
  } seq_state_t;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_UV    = 2'd1,
    FLT_THERM = 2'd2,
    FLT_OC    = 2'd3
  } fault_t;

endpackage

// File: rtl/conv_seq_fault.sv
module conv_seq_fault
  import conv_seq_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic              uv_flag,
  input  logic              oc_flag,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [TEMP_W-1:0] temp_trip,
  input  logic [TEMP_W-1:0] temp_hyst,
  input  logic              in_hot,
  input  logic              switching,
  output fault_t            fault,
  output logic              cool_now
);

  // restart threshold: trip minus hysteresis, clamped at zero
  function automatic logic [TEMP_W-1:0] restart_level(input logic [TEMP_W-1:0] trip,
                                                      input logic [TEMP_W-1:0] hyst);
    if (hyst > trip) return '0;
    return trip - hyst;
  endfunction

  logic hot_trip;
  logic therm_active;

  assign hot_trip     = temp_code > temp_trip;
  assign cool_now     = temp_code <= restart_level(temp_trip, temp_hyst);
  assign therm_active = in_hot ? !cool_now : hot_trip;

  always_comb begin
    if (uv_flag)                    fault = FLT_UV;
    else if (therm_active)          fault = FLT_THERM;
    else if (oc_flag && switching)  fault = FLT_OC;
    else                            fault = FLT_NONE;
  end

endmodule

// File: rtl/conv_seq_hiccup.sv
module conv_seq_hiccup #(
  parameter int HICCUP_CYC = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(HICCUP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HICCUP_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  assign done = run && (cnt == LAST);

  // R7: the off window never runs past its length
  a_r7_hiccup_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < CW'(HICCUP_CYC));

  // R7: completion is a single-cycle event
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/conv_seq_ramp.sv
module conv_seq_ramp #(
  parameter int RAMP_W     = 8,
  parameter int RAMP_FINAL = 150,
  parameter int RAMP_STEP  = 2,
  parameter int PRESCALE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run_up,
  input  logic              run_down,
  output logic [RAMP_W-1:0] ramp,
  output logic              at_final,
  output logic              at_zero
);

  localparam logic [RAMP_W-1:0] FINAL_C = RAMP_W'(RAMP_FINAL);
  localparam logic [RAMP_W:0]   STEP_C  = (RAMP_W+1)'(RAMP_STEP);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  function automatic logic [RAMP_W-1:0] step_up(input logic [RAMP_W-1:0] v);
    logic [RAMP_W:0] s;
    s = {1'b0, v} + STEP_C;
    if (s > {1'b0, FINAL_C}) return FINAL_C;
    return s[RAMP_W-1:0];
  endfunction

  function automatic logic [RAMP_W-1:0] step_down(input logic [RAMP_W-1:0] v);
    logic [RAMP_W:0] s;
    if ({1'b0, v} < STEP_C) return '0;
    s = {1'b0, v} - STEP_C;
    return s[RAMP_W-1:0];
  endfunction

  logic moving;
  logic tick;

  assign moving = run_up || run_down;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            pcnt <= '0;
        else if (!moving)                      pcnt <= '0;
        else if (pcnt == PW'(PRESCALE - 1))    pcnt <= '0;
        else                                   pcnt <= pcnt + 1'b1;
      end
      assign tick = moving && (pcnt == PW'(PRESCALE - 1));
    end else begin : g_nopre
      assign tick = moving;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ramp <= '0;
    else if (clr)              ramp <= '0;
    else if (tick && run_up)   ramp <= step_up(ramp);
    else if (tick && run_down) ramp <= step_down(ramp);
  end

  assign at_final = ramp == FINAL_C;
  assign at_zero  = ramp == '0;

  // R3: code never passes its final value
  a_r3_ramp_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ramp <= FINAL_C);

  // R2: rising phase is monotonic and bounded by one step
  a_r2_rise_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_up && !clr) |=> (ramp >= $past(ramp)) && ({1'b0, ramp} - {1'b0, $past(ramp)} <= STEP_C));

  // R9: falling phase never climbs
  a_r9_fall_mono: assert property (@(posedge clk) disable iff (!rst_n)
    (run_down && !clr) |=> ramp <= $past(ramp));

endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int RAMP_W     = 8,
  parameter int RAMP_FINAL = 150,
  parameter int REG_CODE   = 60,
  parameter int RAMP_STEP  = 2,
  parameter int PRESCALE   = 4,
  parameter int HICCUP_CYC = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              uv_flag,
  input  logic              oc_flag,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [TEMP_W-1:0] temp_trip,
  input  logic [TEMP_W-1:0] temp_hyst,
  output logic              sw_en,
  output logic              stage_hiz,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              ramp_dir,
  output logic              core_active,
  output logic              in_reg
);

  localparam logic [RAMP_W-1:0] REG_C = RAMP_W'(REG_CODE);

  seq_state_t st_q, st_nxt;
  fault_t     fault;
  logic       cool_now;
  logic       switching;
  logic       hic_done;
  logic       at_final, at_zero;
  logic       run_up, run_down, ramp_clr;

  assign switching = (st_q == ST_RISE) || (st_q == ST_HOLD) || (st_q == ST_FALL);

  conv_seq_fault #(.TEMP_W(TEMP_W)) u_fault (
    .uv_flag   (uv_flag),
    .oc_flag   (oc_flag),
    .temp_code (temp_code),
    .temp_trip (temp_trip),
    .temp_hyst (temp_hyst),
    .in_hot    (st_q == ST_HOT),
    .switching (switching),
    .fault     (fault),
    .cool_now  (cool_now)
  );

  conv_seq_hiccup #(.HICCUP_CYC(HICCUP_CYC)) u_hiccup (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_q == ST_HICCUP),
    .done  (hic_done)
  );

  always_comb begin
    st_nxt = st_q;
    unique case (fault)
      FLT_UV:    st_nxt = ST_LOCK;
      FLT_THERM: st_nxt = ST_HOT;
      FLT_OC:    st_nxt = ST_HICCUP;
      default: begin
        unique case (st_q)
          ST_IDLE:   if (en_req) st_nxt = ST_RISE;
          ST_RISE:   if (!en_req) st_nxt = ST_FALL;
                     else if (at_final) st_nxt = ST_HOLD;
          ST_HOLD:   if (!en_req) st_nxt = ST_FALL;
          ST_FALL:   if (en_req) st_nxt = ST_RISE;
                     else if (at_zero) st_nxt = ST_IDLE;
          ST_LOCK,
          ST_HOT:    st_nxt = en_req ? ST_RISE : ST_IDLE;
          ST_HICCUP: if (hic_done) st_nxt = en_req ? ST_RISE : ST_IDLE;
          default:   st_nxt = ST_IDLE;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nxt;
  end

  assign ramp_clr = fault != FLT_NONE;
  assign run_up   = (st_q == ST_RISE) && (st_nxt == ST_RISE);
  assign run_down = (st_q == ST_FALL) && (st_nxt == ST_FALL);

  conv_seq_ramp #(
    .RAMP_W     (RAMP_W),
    .RAMP_FINAL (RAMP_FINAL),
    .RAMP_STEP  (RAMP_STEP),
    .PRESCALE   (PRESCALE)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ramp_clr),
    .run_up   (run_up),
    .run_down (run_down),
    .ramp     (ramp_code),
    .at_final (at_final),
    .at_zero  (at_zero)
  );

  assign sw_en       = switching;
  assign stage_hiz   = !switching;
  assign ramp_dir    = (st_q == ST_RISE) || (st_q == ST_HOLD);
  assign core_active = switching || (st_q == ST_HICCUP);
  assign in_reg      = ramp_code >= REG_C;

  // R5: lockout cuts the stage and clears the reference
  a_r5_uv_cut: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> stage_hiz && (ramp_code == '0) && !core_active);

  // R7: overload while switching opens both switches next cycle
  a_r7_oc_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag && sw_en) |=> stage_hiz && (ramp_code == '0));

  // R6: hot state is kept until the restart threshold is met
  a_r6_hot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOT && !cool_now && !uv_flag) |=> stage_hiz);

  // R10: re-enable during ramp-down keeps the code and turns upward
  a_r10_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FALL && en_req && fault == FLT_NONE) |=> (ramp_code == $past(ramp_code)) && ramp_dir);

  // R9: internals stay powered while the code is still falling
  a_r9_active_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FALL && !at_zero && fault == FLT_NONE) |=> core_active);

endmodule

// File: tb/sim_conv_seq.sv
module sim_conv_seq;

  localparam int TW = 8, RW = 8, FIN = 150, REGC = 60, STEP = 4, PRE = 3, HIC = 8192;
  localparam int M_IDLE = 0, M_RISE = 1, M_HOLD = 2, M_FALL = 3, M_LOCK = 4, M_HOT = 5, M_HIC = 6;

  logic clk = 0, rst_n = 0;
  logic en_req = 0, uv_flag = 0, oc_flag = 0;
  logic [TW-1:0] temp_code = 8'd25, temp_trip = 8'd150, temp_hyst = 8'd20;
  logic sw_en, stage_hiz, ramp_dir, core_active, in_reg;
  logic [RW-1:0] ramp_code;

  int checks = 0, fails = 0;
  bit finished = 0;

  int m_st = M_IDLE, m_ramp = 0, m_pcnt = 0, m_hcnt = 0;

  always #2 clk = ~clk;

  conv_seq #(.TEMP_W(TW), .RAMP_W(RW), .RAMP_FINAL(FIN), .REG_CODE(REGC),
             .RAMP_STEP(STEP), .PRESCALE(PRE), .HICCUP_CYC(HIC)) u0 (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .uv_flag(uv_flag), .oc_flag(oc_flag),
    .temp_code(temp_code), .temp_trip(temp_trip), .temp_hyst(temp_hyst),
    .sw_en(sw_en), .stage_hiz(stage_hiz), .ramp_code(ramp_code), .ramp_dir(ramp_dir),
    .core_active(core_active), .in_reg(in_reg));

  function automatic int up_v(int v);   return (v + STEP > FIN) ? FIN : v + STEP; endfunction
  function automatic int dn_v(int v);   return (v < STEP) ? 0 : v - STEP; endfunction
  function automatic int cool_lvl();    return (temp_hyst > temp_trip) ? 0 : int'(temp_trip) - int'(temp_hyst); endfunction
  function automatic bit m_sw();        return m_st == M_RISE || m_st == M_HOLD || m_st == M_FALL; endfunction

  // reference model, written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_ramp = 0; m_pcnt = 0; m_hcnt = 0;
    end else begin
      int nst; bit hot; bit clr; bit run;
      hot = (m_st == M_HOT) ? !(int'(temp_code) <= cool_lvl()) : (temp_code > temp_trip);
      nst = m_st; clr = 0;
      if (uv_flag) begin nst = M_LOCK; clr = 1; end
      else if (hot) begin nst = M_HOT; clr = 1; end
      else if (oc_flag && m_sw()) begin nst = M_HIC; clr = 1; end
      else case (m_st)
        M_IDLE: if (en_req) nst = M_RISE;
        M_RISE: if (!en_req) nst = M_FALL; else if (m_ramp == FIN) nst = M_HOLD;
        M_HOLD: if (!en_req) nst = M_FALL;
        M_FALL: if (en_req) nst = M_RISE; else if (m_ramp == 0) nst = M_IDLE;
        M_LOCK, M_HOT: nst = en_req ? M_RISE : M_IDLE;
        default: if (m_hcnt == HIC - 1) nst = en_req ? M_RISE : M_IDLE;
      endcase
      run = (m_st == M_RISE || m_st == M_FALL) && nst == m_st;
      if (clr) m_ramp = 0;
      if (run) begin
        if (m_pcnt == PRE - 1) begin
          m_pcnt = 0;
          m_ramp = (m_st == M_RISE) ? up_v(m_ramp) : dn_v(m_ramp);
        end else m_pcnt++;
      end else m_pcnt = 0;
      m_hcnt = (m_st == M_HIC) ? m_hcnt + 1 : 0;
      m_st = nst;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(int'(ramp_code) == m_ramp, "R3", "ramp_code", int'(ramp_code), m_ramp);
    chk(sw_en == m_sw(), "R5", "sw_en", int'(sw_en), int'(m_sw()));
    chk(stage_hiz == !m_sw(), "R7", "stage_hiz", int'(stage_hiz), int'(!m_sw()));
    chk(ramp_dir == (m_st == M_RISE || m_st == M_HOLD), "R9", "ramp_dir", int'(ramp_dir),
        int'(m_st == M_RISE || m_st == M_HOLD));
    chk(core_active == (m_sw() || m_st == M_HIC), "R9", "core_active", int'(core_active),
        int'(m_sw() || m_st == M_HIC));
    chk(in_reg == (m_ramp >= REGC), "R4", "in_reg", int'(in_reg), int'(m_ramp >= REGC));
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_model();
    end
  endtask

  initial begin
    int r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(sw_en == 0 && stage_hiz == 1 && ramp_code == 0 && ramp_dir == 0 && core_active == 0 && in_reg == 0,
        "R1", "reset outputs", int'({sw_en, stage_hiz, ramp_dir, core_active, in_reg}), 5'b01000);

    // R2 soft-start timing
    en_req = 1;
    cyc(3);
    chk(sw_en == 1 && ramp_code == 0 && ramp_dir == 1, "R2", "start before first step", int'(ramp_code), 0);
    cyc(1);
    chk(ramp_code == STEP, "R2", "first step", int'(ramp_code), STEP);
    cyc(3);
    chk(ramp_code == 2 * STEP, "R2", "second step", int'(ramp_code), 2 * STEP);
    cyc(200);
    chk(ramp_code == FIN, "R3", "saturated final", int'(ramp_code), FIN);
    chk(in_reg == 1, "R4", "in regulation", int'(in_reg), 1);

    // R7 hiccup length
    oc_flag = 1; cyc(1); oc_flag = 0;
    chk(stage_hiz == 1 && ramp_code == 0 && core_active == 1, "R7", "oc cut", int'(stage_hiz), 1);
    cyc(HIC - 1);
    chk(stage_hiz == 1, "R7", "still off at end of window", int'(stage_hiz), 1);
    cyc(1);
    chk(sw_en == 1 && ramp_code == 0, "R7", "restart after window", int'(sw_en), 1);
    // persistent overload repeats
    oc_flag = 1; cyc(HIC + 3);
    chk(stage_hiz == 1 && core_active == 1, "R7", "repeat hiccup", int'(stage_hiz), 1);
    oc_flag = 0; cyc(HIC + 200);
    chk(ramp_code == FIN, "R7", "recovered", int'(ramp_code), FIN);

    // R6 thermal boundaries
    temp_code = 8'd150; cyc(5);
    chk(sw_en == 1, "R6", "equal to trip keeps running", int'(sw_en), 1);
    temp_code = 8'd151; cyc(1);
    chk(sw_en == 0 && ramp_code == 0, "R6", "trip", int'(sw_en), 0);
    temp_code = 8'd131; cyc(20);
    chk(sw_en == 0, "R6", "above restart level", int'(sw_en), 0);
    temp_code = 8'd130; cyc(1);
    chk(sw_en == 1 && ramp_code == 0, "R6", "restart at level", int'(sw_en), 1);
    temp_code = 8'd25; cyc(200);

    // R8 priority
    uv_flag = 1; oc_flag = 1; temp_code = 8'd200; cyc(1);
    chk(core_active == 0 && stage_hiz == 1, "R8", "uv over oc (no hiccup)", int'(core_active), 0);
    uv_flag = 0; cyc(5);
    chk(core_active == 0 && sw_en == 0, "R8", "thermal over oc", int'(core_active), 0);
    oc_flag = 0; temp_code = 8'd25; cyc(200);

    // R9 / R10 ramp-down and resume
    en_req = 0; cyc(30);
    r = int'(ramp_code);
    chk(ramp_dir == 0 && core_active == 1 && r < FIN, "R9", "falling", r, FIN - 40);
    en_req = 1; cyc(1);
    chk(int'(ramp_code) == r && ramp_dir == 1, "R10", "resume from current", int'(ramp_code), r);
    cyc(6);
    chk(int'(ramp_code) == up_v(up_v(r)), "R10", "rising again", int'(ramp_code), up_v(up_v(r)));
    cyc(200);
    en_req = 0; cyc(200);
    chk(core_active == 0 && ramp_code == 0, "R9", "fully off", int'(core_active), 0);

    // R7 overload ignored while idle
    oc_flag = 1; cyc(10);
    chk(core_active == 0 && ramp_code == 0, "R7", "oc ignored idle", int'(core_active), 0);
    oc_flag = 0;

    // R5 lockout during ramp-down
    en_req = 1; cyc(200); en_req = 0; cyc(10);
    uv_flag = 1; cyc(1);
    chk(core_active == 0 && ramp_code == 0, "R5", "uv preempts fall", int'(core_active), 0);
    en_req = 1; cyc(3); uv_flag = 0; cyc(1);
    chk(sw_en == 1 && ramp_code == 0, "R5", "restart after uv", int'(sw_en), 1);

    // constrained random phase
    for (int k = 0; k < 30000; k++) begin
      if ($urandom_range(0, 399) == 0) en_req = ~en_req;
      if ($urandom_range(0, 1499) == 0) uv_flag = 1;
      else if (uv_flag && $urandom_range(0, 19) == 0) uv_flag = 0;
      oc_flag = ($urandom_range(0, 5999) == 0);
      if ($urandom_range(0, 49) == 0) temp_code = 8'($urandom_range(120, 160));
      if ($urandom_range(0, 4999) == 0) temp_hyst = 8'($urandom_range(0, 40));
      cyc(1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #760000;
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule